// File: doc/BRIEF.md
# Pseudo-Channel Burst Commit Scheduler

This block times the commit of memory-transaction flits onto a set of pseudo-channels. Each accepted flit is steered to one channel by a field of its address. The channel's commit window opens at the later of the flit's arrival time and the moment the channel frees up. A read/write turnaround penalty is added when the direction changes, and the window lasts a fixed burst time. Reads and writes share one busy-until timer per channel. Each flit's finish time is folded into a running maximum for its transaction.

When the flit flagged last has been committed, the transaction waits in a tag-indexed table until the free-running cycle counter reaches its finish time, and a completion pulse then carries the tag out. New flits keep flowing while transactions wait. Intake stalls only when a flit opens a tag whose previous transaction has not yet completed. Time is counted in clock cycles. The burst time, turnaround penalty and header-decode overhead are integer cycle parameters.

Top module: `pc_burst_sched`

## Requirements
- R1: The channel of a flit is `(in_addr >> log2(BURST_BYTES)) & (NUM_CH-1)`, and both parameters are powers of two. With the bench setting (BURST_BYTES=16, NUM_CH=4) this is address bits [5:4]. Lower and higher bits have no effect on the channel.
- R2: Reads and writes to a channel share one busy-until value. A flit's start is `max(arrival, busy[ch]) + penalty`, its finish is `start + BURST_CYC`, and the channel's busy-until becomes that finish.
- R3: The penalty is TURN_CYC when the channel has a recorded last direction that differs from the flit's direction (`in_wr`=1 write, 0 read). Otherwise it is zero. After reset no channel has a recorded direction.
- R4: On the first flit of a transaction (its tag's entry is free), the arrival time is the current cycle plus OVH_CYC. On later flits it is the current cycle. The transaction's finish starts out as that first flit's finish.
- R5: Every later flit of a transaction raises the transaction's finish to the maximum of its current value and the flit's finish.
- R6: The time counter is 0 in the first cycle after reset and rises by one per cycle. A flit accepted in cycle N is timed with now = N. The completion pulse (`done_valid` high for one cycle with `done_tag`) appears in the cycle after the counter first reaches the transaction's finish, unless R9 delays it.
- R7: While transactions wait for completion, flits with other tags are accepted without stall.
- R8: `in_ready` is low exactly while the entry of `in_tag` holds a transaction whose last flit was accepted and which has not yet completed.
- R9: When several transactions are due in the same cycle, they complete one per cycle, lowest tag first.
- R10: After reset, `in_ready` is high, `done_valid` is low, and all channels are idle with busy-until 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Flit present |
| in_ready | output | 1 | Flit accepted when high with in_valid |
| in_addr | input | ADDR_W | Flit byte address |
| in_wr | input | 1 | 1 = write, 0 = read |
| in_tag | input | TAG_W | Transaction tag |
| in_last | input | 1 | Final flit of the transaction |
| done_valid | output | 1 | Completion pulse |
| done_tag | output | TAG_W | Tag of the completing transaction |

## Verification
All internal state surfaces only as completion timing and `in_ready`. A wrong busy-until value, a stale direction bit or a wrong channel index therefore shows up as a completion pulse that is early or late by whole burst or penalty counts. This happens for the first transaction that touches the affected channel after the fault, often several transactions later. A table entry stuck in the waiting state shows up at once as `in_ready` held low for that tag. An entry freed too early shows up as a missing or doubled pulse. The bench keeps a cycle-exact model of every channel and tag entry and compares the pulse and `in_ready` in every cycle, so any divergence is caught in the cycle it first reaches a port.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  localparam int CYC_W = 32;
  typedef logic [CYC_W-1:0] cyc_t;

  typedef enum logic [1:0] {
    TX_FREE = 2'd0,
    TX_OPEN = 2'd1,
    TX_WAIT = 2'd2
  } txn_st_e;

  function automatic cyc_t max_cyc(cyc_t a, cyc_t b);
    return (a > b) ? a : b;
  endfunction

  // turnaround cost: only when a direction is on record and differs
  function automatic cyc_t turn_cost(logic seen, logic last_wr, logic wr, cyc_t pen);
    return (seen && (last_wr != wr)) ? pen : '0;
  endfunction

  // commit window end for one flit on one channel
  function automatic cyc_t commit_finish(cyc_t arrive, cyc_t busy, cyc_t pen, cyc_t burst);
    return max_cyc(arrive, busy) + pen + burst;
  endfunction

endpackage

// File: rtl/pcs_chan_timer.sv
module pcs_chan_timer
  import pcs_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int BURST_CYC = 8,
  parameter int TURN_CYC  = 0,
  localparam int CH_W     = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [CH_W-1:0] ch,
  input  logic            wr,
  input  cyc_t            arrive,
  output cyc_t            finish,
  output cyc_t            busy_sel
);

  cyc_t busy_q [NUM_CH];
  cyc_t pen;

  assign busy_sel = busy_q[ch];
  assign finish   = commit_finish(arrive, busy_sel, pen, cyc_t'(BURST_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) busy_q[i] <= '0;
    end else if (fire) begin
      busy_q[ch] <= finish;
    end
  end

  generate
    if (TURN_CYC == 0) begin : g_no_turn
      assign pen = '0;
    end else begin : g_turn
      logic [NUM_CH-1:0] seen_q;
      logic [NUM_CH-1:0] lwr_q;
      assign pen = turn_cost(seen_q[ch], lwr_q[ch], wr, cyc_t'(TURN_CYC));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          seen_q <= '0;
          lwr_q  <= '0;
        end else if (fire) begin
          seen_q[ch] <= 1'b1;
          lwr_q[ch]  <= wr;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/pcs_txn_table.sv
module pcs_txn_table
  import pcs_pkg::*;
#(
  parameter int TAG_W  = 2,
  localparam int NUM_TAG = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cyc_t             now,
  input  logic [TAG_W-1:0] q_tag,
  output logic             q_first,
  output logic             q_wait,
  input  logic             acc_fire,
  input  logic             acc_last,
  input  cyc_t             acc_finish,
  output logic             done_valid,
  output logic [TAG_W-1:0] done_tag,
  output cyc_t             done_lf
);

  txn_st_e st_q [NUM_TAG];
  cyc_t    lf_q [NUM_TAG];

  logic             due_any;
  logic [TAG_W-1:0] due_idx;

  assign q_first = (st_q[q_tag] == TX_FREE);
  assign q_wait  = (st_q[q_tag] == TX_WAIT);

  // lowest waiting tag whose finish time has been reached
  always_comb begin
    due_any = 1'b0;
    due_idx = '0;
    for (int i = NUM_TAG - 1; i >= 0; i--) begin
      if (st_q[i] == TX_WAIT && lf_q[i] <= now) begin
        due_any = 1'b1;
        due_idx = TAG_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TAG; i++) begin
        st_q[i] <= TX_FREE;
        lf_q[i] <= '0;
      end
      done_valid <= 1'b0;
      done_tag   <= '0;
      done_lf    <= '0;
    end else begin
      done_valid <= due_any;
      done_tag   <= due_idx;
      done_lf    <= lf_q[due_idx];
      if (due_any) st_q[due_idx] <= TX_FREE;
      if (acc_fire) begin
        st_q[q_tag] <= acc_last ? TX_WAIT : TX_OPEN;
        lf_q[q_tag] <= q_first ? acc_finish : max_cyc(lf_q[q_tag], acc_finish);
      end
    end
  end

endmodule

// File: rtl/pc_burst_sched.sv
module pc_burst_sched
  import pcs_pkg::*;
#(
  parameter int ADDR_W      = 37,
  parameter int NUM_CH      = 8,
  parameter int BURST_BYTES = 256,
  parameter int BURST_CYC   = 8,
  parameter int TURN_CYC    = 0,
  parameter int OVH_CYC     = 0,
  parameter int TAG_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic             in_wr,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             in_last,
  output logic             done_valid,
  output logic [TAG_W-1:0] done_tag
);

  localparam int CH_W  = $clog2(NUM_CH);
  localparam int OFF_W = $clog2(BURST_BYTES);

  cyc_t            now_q;
  logic            acc_fire;
  logic [CH_W-1:0] acc_ch;
  cyc_t            acc_arrive;
  cyc_t            acc_finish;
  cyc_t            acc_busy;
  logic            tag_first;
  logic            tag_wait;
  cyc_t            done_lf;

  function automatic logic [CH_W-1:0] chan_of(logic [ADDR_W-1:0] a);
    return CH_W'((a >> OFF_W) & ADDR_W'(NUM_CH - 1));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_q + 1'b1;
  end

  assign in_ready   = !tag_wait;
  assign acc_fire   = in_valid && in_ready;
  assign acc_ch     = chan_of(in_addr);
  assign acc_arrive = tag_first ? now_q + cyc_t'(OVH_CYC) : now_q;

  pcs_chan_timer #(
    .NUM_CH   (NUM_CH),
    .BURST_CYC(BURST_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_chan (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (acc_fire),
    .ch      (acc_ch),
    .wr      (in_wr),
    .arrive  (acc_arrive),
    .finish  (acc_finish),
    .busy_sel(acc_busy)
  );

  pcs_txn_table #(
    .TAG_W(TAG_W)
  ) u_tab (
    .clk       (clk),
    .rst_n     (rst_n),
    .now       (now_q),
    .q_tag     (in_tag),
    .q_first   (tag_first),
    .q_wait    (tag_wait),
    .acc_fire  (acc_fire),
    .acc_last  (in_last),
    .acc_finish(acc_finish),
    .done_valid(done_valid),
    .done_tag  (done_tag),
    .done_lf   (done_lf)
  );

endmodule

// File: rtl/pcs_sched_chk.sv
module pcs_sched_chk
  import pcs_pkg::*;
#(
  parameter int TAG_W     = 3,
  parameter int BURST_CYC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [TAG_W-1:0] in_tag,
  input logic             in_last,
  input logic             done_valid,
  input logic [TAG_W-1:0] done_tag,
  input cyc_t             done_lf,
  input cyc_t             now_q,
  input logic             acc_fire,
  input cyc_t             acc_finish,
  input cyc_t             acc_busy
);

  // R6
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> now_q == $past(now_q) + 1'b1);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !(done_valid && done_tag == $past(done_tag)));

  // R6
  done_not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> done_lf < now_q);

  // R8
  closed_tag_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !(in_valid && in_ready && in_tag == $past(in_tag)));

  // R2
  finish_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |-> acc_finish >= acc_busy + cyc_t'(BURST_CYC));

  // R2
  finish_after_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |-> acc_finish >= now_q + cyc_t'(BURST_CYC));

endmodule

bind pc_burst_sched pcs_sched_chk #(
  .TAG_W    (TAG_W),
  .BURST_CYC(BURST_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_tag    (in_tag),
  .in_last   (in_last),
  .done_valid(done_valid),
  .done_tag  (done_tag),
  .done_lf   (done_lf),
  .now_q     (now_q),
  .acc_fire  (acc_fire),
  .acc_finish(acc_finish),
  .acc_busy  (acc_busy)
);

// File: tb/tb_pc_burst_sched.sv
module tb_pc_burst_sched;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int NCH    = 4;
  localparam int BB     = 16;
  localparam int BURST  = 3;
  localparam int TURN   = 2;
  localparam int OVH    = 1;
  localparam int TW     = 2;
  localparam int NTAG   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [ADDR_W-1:0] in_addr = '0;
  logic in_wr = 1'b0;
  logic [TW-1:0] in_tag = '0;
  logic in_last = 1'b0;
  logic done_valid;
  logic [TW-1:0] done_tag;

  int errors = 0;
  int checks = 0;
  int unsigned tnow = 0;
  int cyc = 0;

  // bench model state
  int unsigned mbusy [NCH];
  bit          mseen [NCH];
  bit          mlwr  [NCH];
  int          mst   [NTAG];   // 0 free, 1 open, 2 waiting
  int unsigned mlf   [NTAG];

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_burst_sched #(
    .ADDR_W(ADDR_W), .NUM_CH(NCH), .BURST_BYTES(BB), .BURST_CYC(BURST),
    .TURN_CYC(TURN), .OVH_CYC(OVH), .TAG_W(TW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_wr(in_wr), .in_tag(in_tag), .in_last(in_last),
    .done_valid(done_valid), .done_tag(done_tag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at t=%0d", req, act, exp, tnow);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  // one clock cycle: drive at negedge, update the model after the edge
  task automatic step(input bit v, input int a, input bit w, input int t, input bit l,
                      output bit acc);
    int ch, st, arr, fin, due_idx, ndue;
    bit first;
    int unsigned n;
    in_valid = v; in_addr = ADDR_W'(a); in_wr = w; in_tag = TW'(t); in_last = l;
    #1;
    if (v) chk(in_ready == (mst[t] != 2), (mst[t] == 2) ? "R8 stall" : "R7 accept",
               int'(in_ready), int'(mst[t] != 2));
    acc = v && in_ready;
    @(posedge clk);
    tnow++;
    @(negedge clk);
    n = tnow - 1;
    due_idx = -1; ndue = 0;
    for (int i = NTAG - 1; i >= 0; i--)
      if (mst[i] == 2 && mlf[i] <= n) begin due_idx = i; ndue++; end
    chk(done_valid == (due_idx >= 0), (ndue > 1) ? "R9 pulse" : "R6 pulse",
        int'(done_valid), int'(due_idx >= 0));
    if (due_idx >= 0) begin
      chk(int'(done_tag) == due_idx, (ndue > 1) ? "R9 order" : "R6 tag",
          int'(done_tag), due_idx);
      mst[due_idx] = 0;
    end
    if (acc) begin
      first = (mst[t] == 0);
      arr = first ? int'(n) + OVH : int'(n);
      ch = (a / BB) % NCH;
      st = (arr > int'(mbusy[ch])) ? arr : int'(mbusy[ch]);
      if (mseen[ch] && mlwr[ch] != w) st += TURN;
      fin = st + BURST;
      mbusy[ch] = fin; mseen[ch] = 1'b1; mlwr[ch] = w;
      mlf[t] = first ? fin : ((int'(mlf[t]) > fin) ? mlf[t] : fin);
      mst[t] = l ? 2 : 1;
    end
    in_valid = 1'b0;
  endtask

  task automatic idle(input int k);
    bit acc;
    for (int i = 0; i < k; i++) step(0, 0, 0, 0, 0, acc);
  endtask

  task automatic wait_done(input int t, input int unsigned exp_t, input string req);
    bit acc;
    int g = 0;
    while (!(done_valid && int'(done_tag) == t) && g < 64) begin
      step(0, 0, 0, 0, 0, acc);
      g++;
    end
    chk(tnow == exp_t, req, int'(tnow), int'(exp_t));
  endtask

  initial begin
    bit acc;
    int unsigned n0;
    int fl, busy_cnt;
    for (int i = 0; i < NCH; i++) begin mbusy[i] = 0; mseen[i] = 0; mlwr[i] = 0; end
    for (int i = 0; i < NTAG; i++) begin mst[i] = 0; mlf[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk(in_ready == 1'b1, "R10 ready", int'(in_ready), 1);
    chk(done_valid == 1'b0, "R10 done", int'(done_valid), 0);

    // R4 / R6: single read on fresh channel 0
    n0 = tnow;
    step(1, 12'h000, 0, 0, 1, acc);
    wait_done(0, n0 + OVH + BURST + 1, "R4 first-flit overhead");

    // R1 / R2 / R3: write then read on channel 1 (addresses differ outside [5:4])
    n0 = tnow;
    step(1, 12'hF10, 1, 1, 1, acc);
    step(1, 12'h395, 0, 2, 1, acc);
    wait_done(1, n0 + 5, "R1 channel select");
    wait_done(2, n0 + 10, "R3 turnaround on shared timer");

    // R5: three-flit write, two on channel 2, one on channel 3
    n0 = tnow;
    step(1, 12'h020, 1, 3, 0, acc);
    step(1, 12'h021, 1, 3, 0, acc);
    step(1, 12'h030, 1, 3, 1, acc);
    // R8: reusing tag 3 must stall
    step(1, 12'h000, 0, 3, 1, acc);
    chk(acc == 1'b0, "R8 closed tag", int'(acc), 0);
    // R7: other tag flows while tag 3 waits
    step(1, 12'h000, 0, 0, 1, acc);
    chk(acc == 1'b1, "R7 intake not blocked", int'(acc), 1);
    wait_done(3, n0 + 8, "R5 max finish");
    idle(20);

    // near-exhaustive sweep: every channel x direction x tag x length
    for (int k = 0; k < 384; k++) begin
      fl = (k % 3) + 1;
      for (int f = 0; f < fl; f++) begin
        acc = 1'b0;
        while (!acc)
          step(1, ((k * 37 + f * 16) % 4096), bit'(((k >> 1) ^ f) & 1), (k * 3 + (k / 8)) % NTAG,
               (f == fl - 1), acc);
      end
      if (k % 5 == 0) idle(k % 7);
    end
    idle(60);
    busy_cnt = 0;
    for (int i = 0; i < NTAG; i++) if (mst[i] != 0) busy_cnt++;
    chk(busy_cnt == 0, "R6 all drained", busy_cnt, 0);
    chk(in_ready == 1'b1, "R8 ready after drain", int'(in_ready), 1);
    summary();
  end

endmodule